// File: doc/BRIEF.md
# Bus Access Fault Checker with Status Capture

This block watches every CPU bus cycle and decides, in the same cycle, whether the access is allowed. It looks at the address and the transfer size, and at whether the cycle is a read or a write. It also takes the processor status word and the map state of the addressed page. A refused access raises a bus error. Most fault classes also request a level-7 interrupt. The checks run in a fixed priority order, and each fault class leaves its own code in a general status word.

On a fault, the block also records two bus status words. One holds a code for the transfer size and byte lane, together with the top address byte. The other holds the low sixteen address bits. Software reads these words after the exception. It resets all three words to all-ones with a single clear strobe. Outside a fault or a clear, the three words keep their values.

Top module: `bus_access_guard`

## Requirements
- R1: After reset, the general status word and both bus status words read 0xFFFF, and fault, bus error and level-7 request are all low.
- R2: A page is treated as absent when its two state bits are both 0. An access to an absent page at an address of 0x3FFFFF or below faults in any processor mode. It raises both the bus error and the level-7 request. The general status captured is 0x8BFF for a write and 0xCBFF for a read.
- R3: A user-mode access to an address of 0x07FFFF or below, on a page that is present, faults with the bus error and the level-7 request. The status captured is 0x9BFF for a write and 0xDBFF for a read.
- R4: A user-mode write to a present page at an address from 0x080000 to 0x3FFFFF faults when the page write-enable bit is 0. It raises both signals and captures 0x9BFF. A user-mode read of such a page does not fault.
- R5: A user-mode access to an address of 0x400000 or above raises only the bus error; the level-7 request stays low. The status captured is 0x9AFF for a write and 0xDAFF for a read.
- R6: The checks are tried in the order R2, R3, R4, R5, and the first one that matches sets the fault. For example, a user access to an absent page in the low kernel range captures the R2 code.
- R7: The processor is in supervisor mode when bit 13 of the status word input is 1. A supervisor access skips the checks of R3, R4 and R5.
- R8: When the parity-interrupt enable input is 1 during a fault, the captured general status also has bit 10 (0x0400) set.
- R9: On a fault, bus status 0 is captured as the size code OR'ed with address bits 23:16. The size code is 0x7C00 for a word or long transfer, 0x7E00 for a byte at an odd address and 0x7D00 for a byte at an even address. Size input encoding: 0 = byte, 1 = word, 2 or 3 = long.
- R10: On a fault, bus status 1 is captured as address bits 15:0.
- R11: The three status words change only on the clock edge that ends a faulting cycle, or on a clear strobe. At all other times they hold their values.
- R12: A clear strobe sets all three words to 0xFFFF on the next edge. If a fault happens in the same cycle, the clear takes priority over the capture.
- R13: Fault, bus error and level-7 request are combinational from the access inputs. They are high only during a cycle that has the access-valid input high, so each faulting access gives a bus-error pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A CPU bus cycle is present this clock |
| acc_addr | input | 24 | Byte address of the access |
| acc_size | input | 2 | Transfer size: 0 byte, 1 word, 2/3 long |
| acc_write | input | 1 | 1 = write, 0 = read |
| cpu_sr | input | 16 | Processor status word; bit 13 = supervisor |
| pg_state | input | 2 | Map state bits of the addressed page; 00 = absent |
| pg_wr_en | input | 1 | Write-enable bit of the addressed page |
| par_int_en | input | 1 | Parity-interrupt enable, folded into the general status |
| clr_stat | input | 1 | Clear strobe for all three status words |
| fault | output | 1 | The access is refused |
| berr_pulse | output | 1 | Bus error to the CPU |
| lvl7_req | output | 1 | Level-7 interrupt request |
| gen_stat | output | 16 | Captured general status word |
| bus_stat0 | output | 16 | Captured size/lane code and address bits 23:16 |
| bus_stat1 | output | 16 | Captured address bits 15:0 |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 16-bit status words, a RAM top of 0x3FFFFF and a kernel top of 0x07FFFF. With these values the bench can reach each range edge with one directed access. The tests place accesses just below and above the kernel limit and at the start of the I/O space. Each fault class is tried in both directions and with both supervisor and user status words, including a user status word with other bits set. The bench also drives a clear in the same cycle as a fault, to show that the clear wins.

// File: rtl/bag_pkg.sv
// Shared types for the bus access guard.
// Assumes: one fault class is reported per access; NONE means allowed.
package bag_pkg;

    typedef enum logic [2:0] {
        FC_NONE  = 3'd0,
        FC_PAGE  = 3'd1,   // page absent in RAM space
        FC_KERN  = 3'd2,   // user touched kernel range
        FC_WPROT = 3'd3,   // user write to write-protected page
        FC_UIO   = 3'd4    // user touched I/O space
    } fclass_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LNG2 = 2'd3
    } xfer_size_e;

endpackage

// File: rtl/bag_classify.sv
// Fault classifier: looks at one access and names the first fault class
// that matches, in fixed priority order.
// Assumes: the page state and write-enable inputs belong to acc_addr.
module bag_classify
    import bag_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] RAM_TOP  = 24'h3FFFFF,
    parameter logic [ADDR_W-1:0] KERN_TOP = 24'h07FFFF
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              supv,
    input  logic [1:0]        pg_state,
    input  logic              pg_we,
    output fclass_e           cls
);

    logic in_ram;
    logic in_kern;
    logic absent;

    // Decode the address range and the page presence.
    always_comb begin
        in_ram  = (addr <= RAM_TOP);
        in_kern = (addr <= KERN_TOP);
        absent  = (pg_state == 2'b00);
    end

    // Priority chain: absent page, kernel, write protect, user I/O.
    always_comb begin
        cls = FC_NONE;
        if (valid) begin
            if (in_ram && absent)
                cls = FC_PAGE;
            else if (!supv && in_kern)
                cls = FC_KERN;
            else if (!supv && write && in_ram && !pg_we)
                cls = FC_WPROT;
            else if (!supv && !in_ram)
                cls = FC_UIO;
        end
    end

endmodule

// File: rtl/bag_encode.sv
// Status encoder: builds the general status word and the two bus status
// words that a fault of class cls would leave behind.
// Assumes: ADDR_W is between 17 and 16+STAT_W.
module bag_encode
    import bag_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int STAT_W = 16
) (
    input  fclass_e           cls,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              write,
    input  logic              pie,
    output logic [STAT_W-1:0] gen_code,
    output logic [STAT_W-1:0] b0_code,
    output logic [STAT_W-1:0] b1_code
);

    localparam int HI_W = ADDR_W - 16;
    localparam logic [STAT_W-1:0] GEN_PAGE = 16'h8BFF;
    localparam logic [STAT_W-1:0] GEN_PROT = 16'h9BFF;
    localparam logic [STAT_W-1:0] GEN_UIO  = 16'h9AFF;
    localparam logic [STAT_W-1:0] RD_FLAG  = 16'h4000;
    localparam logic [STAT_W-1:0] PIE_FLAG = 16'h0400;
    localparam logic [STAT_W-1:0] LN_WIDE  = 16'h7C00;
    localparam logic [STAT_W-1:0] LN_EVEN  = 16'h7D00;
    localparam logic [STAT_W-1:0] LN_ODD   = 16'h7E00;

    logic [STAT_W-1:0] base;
    logic [STAT_W-1:0] lane;

    // Pick the class base code, then fold in the direction and parity flags.
    always_comb begin
        unique case (cls)
            FC_PAGE:           base = GEN_PAGE;
            FC_KERN, FC_WPROT: base = GEN_PROT;
            FC_UIO:            base = GEN_UIO;
            default:           base = '1;
        endcase
        gen_code = base | (write ? '0 : RD_FLAG) | (pie ? PIE_FLAG : '0);
    end

    // Size and byte-lane code joined with the top address bits.
    always_comb begin
        if (size == SZ_BYTE)
            lane = addr[0] ? LN_ODD : LN_EVEN;
        else
            lane = LN_WIDE;
        b0_code = lane | {{(STAT_W-HI_W){1'b0}}, addr[ADDR_W-1:16]};
        b1_code = addr[15:0];
    end

endmodule

// File: rtl/bag_status_regs.sv
// Status register bank: NREG words that reset/clear to all-ones and load
// on a capture strobe; clear wins over capture.
// Assumes: cap and clr are single-cycle strobes from the same clock domain.
module bag_status_regs #(
    parameter int NREG = 3,
    parameter int W    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  cap,
    input  logic [NREG-1:0][W-1:0] d_in,
    output logic [NREG-1:0][W-1:0] q_out
);

    logic [W-1:0] q_r [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_word
        // One status word: reset and clear to ones, else load on capture.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_r[i] <= '1;
            else if (clr)
                q_r[i] <= '1;
            else if (cap)
                q_r[i] <= d_in[i];
        end
        assign q_out[i] = q_r[i];
    end

endmodule

// File: rtl/bus_access_guard.sv
// Bus access guard: classifies each CPU bus cycle, flags a bus error and
// a level-7 request in the same cycle, and captures three status words.
// Assumes: page state and write-enable come from the map lookup of acc_addr
// in the same cycle; the supervisor flag is bit SUPV_BIT of cpu_sr.
module bus_access_guard
    import bag_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter int                STAT_W   = 16,
    parameter int                SR_W     = 16,
    parameter int                SUPV_BIT = 13,
    parameter logic [ADDR_W-1:0] RAM_TOP  = 24'h3FFFFF,
    parameter logic [ADDR_W-1:0] KERN_TOP = 24'h07FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_write,
    input  logic [SR_W-1:0]   cpu_sr,
    input  logic [1:0]        pg_state,
    input  logic              pg_wr_en,
    input  logic              par_int_en,
    input  logic              clr_stat,
    output logic              fault,
    output logic              berr_pulse,
    output logic              lvl7_req,
    output logic [STAT_W-1:0] gen_stat,
    output logic [STAT_W-1:0] bus_stat0,
    output logic [STAT_W-1:0] bus_stat1
);

    localparam int NREG = 3;

    fclass_e                       cls;
    logic                          supv;
    logic [STAT_W-1:0]             gen_code, b0_code, b1_code;
    logic [NREG-1:0][STAT_W-1:0]   d_words, q_words;

    assign supv = cpu_sr[SUPV_BIT];

    bag_classify #(
        .ADDR_W(ADDR_W), .RAM_TOP(RAM_TOP), .KERN_TOP(KERN_TOP)
    ) u_cls (
        .valid(acc_valid), .addr(acc_addr), .write(acc_write),
        .supv(supv), .pg_state(pg_state), .pg_we(pg_wr_en), .cls(cls)
    );

    bag_encode #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_enc (
        .cls(cls), .addr(acc_addr), .size(acc_size), .write(acc_write),
        .pie(par_int_en), .gen_code(gen_code), .b0_code(b0_code),
        .b1_code(b1_code)
    );

    // Fault signals: every class gives a bus error; all but user I/O interrupt.
    always_comb begin
        fault      = (cls != FC_NONE);
        berr_pulse = fault;
        lvl7_req   = fault && (cls != FC_UIO);
    end

    assign d_words = {b1_code, b0_code, gen_code};

    bag_status_regs #(.NREG(NREG), .W(STAT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .clr(clr_stat), .cap(fault),
        .d_in(d_words), .q_out(q_words)
    );

    assign gen_stat  = q_words[0];
    assign bus_stat0 = q_words[1];
    assign bus_stat1 = q_words[2];

    // R5
    lvl7_needs_berr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl7_req |-> berr_pulse);

    // R13
    idle_no_berr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !berr_pulse && !lvl7_req);

    // R7
    supv_io_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cpu_sr[SUPV_BIT] && acc_addr > RAM_TOP) |-> !fault);

    // R12
    clear_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stat |=> (gen_stat == '1 && bus_stat0 == '1 && bus_stat1 == '1));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !clr_stat) |=> ($stable(gen_stat) && $stable(bus_stat0)
                                   && $stable(bus_stat1)));

    // R10
    addr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !clr_stat) |=> bus_stat1 == $past(acc_addr[15:0]));

endmodule

// File: tb/bus_access_guard_tb.sv
module bus_access_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid;
    logic [23:0] acc_addr;
    logic [1:0]  acc_size;
    logic        acc_write;
    logic [15:0] cpu_sr;
    logic [1:0]  pg_state;
    logic        pg_wr_en;
    logic        par_int_en;
    logic        clr_stat;
    logic        fault, berr_pulse, lvl7_req;
    logic [15:0] gen_stat, bus_stat0, bus_stat1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [15:0] SUP  = 16'h2000;
    localparam logic [15:0] USR  = 16'h0700;

    always #4 clk = ~clk;

    bus_access_guard u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_write(acc_write), .cpu_sr(cpu_sr),
        .pg_state(pg_state), .pg_wr_en(pg_wr_en), .par_int_en(par_int_en),
        .clr_stat(clr_stat), .fault(fault), .berr_pulse(berr_pulse),
        .lvl7_req(lvl7_req), .gen_stat(gen_stat), .bus_stat0(bus_stat0),
        .bus_stat1(bus_stat1)
    );

    task automatic chk(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one access at a falling edge and check the combinational outputs.
    task automatic access(input string tag, input logic [23:0] a,
                          input logic [1:0] sz, input logic wr,
                          input logic [15:0] sr, input logic [1:0] pg,
                          input logic we, input logic pie, input logic clr,
                          input logic e_flt, input logic e_l7);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = wr;
        cpu_sr = sr; pg_state = pg; pg_wr_en = we; par_int_en = pie;
        clr_stat = clr;
        #1;
        chk({tag, " fault"}, {15'd0, fault}, {15'd0, e_flt});
        chk({tag, " berr"},  {15'd0, berr_pulse}, {15'd0, e_flt});
        chk({tag, " lvl7"},  {15'd0, lvl7_req}, {15'd0, e_l7});
        @(negedge clk);
        acc_valid = 1'b0; clr_stat = 1'b0;
        #1;
        // R13: bus error gone once the cycle ends
        chk({tag, " R13 berr after"}, {15'd0, berr_pulse}, 16'd0);
    endtask

    task automatic regs(input string tag, input logic [15:0] g,
                        input logic [15:0] b0, input logic [15:0] b1);
        chk({tag, " gen"},  gen_stat,  g);
        chk({tag, " bsr0"}, bus_stat0, b0);
        chk({tag, " bsr1"}, bus_stat1, b1);
    endtask

    task automatic t_reset();
        regs("R1 reset", 16'hFFFF, 16'hFFFF, 16'hFFFF);
        chk("R1 fault", {15'd0, fault}, 16'd0);
    endtask

    task automatic t_page();
        access("R2 wr", 24'h123456, 2'd1, 1'b1, USR, 2'b00, 1'b1, 1'b0, 1'b0, 1, 1);
        regs("R2 R9 R10 wr", 16'h8BFF, 16'h7C12, 16'h3456);
        access("R2 rd sup", 24'h0A0001, 2'd0, 1'b0, SUP, 2'b00, 1'b1, 1'b0, 1'b0, 1, 1);
        regs("R2 R9 rd odd", 16'hCBFF, 16'h7E0A, 16'h0001);
    endtask

    task automatic t_kernel();
        access("R3 rd", 24'h07FFF0, 2'd2, 1'b0, USR, 2'b10, 1'b1, 1'b1, 1'b0, 1, 1);
        regs("R3 R8 rd", 16'hDFFF, 16'h7C07, 16'hFFF0);
        access("R3 wr", 24'h040010, 2'd1, 1'b1, USR, 2'b11, 1'b1, 1'b0, 1'b0, 1, 1);
        regs("R3 wr", 16'h9BFF, 16'h7C04, 16'h0010);
    endtask

    task automatic t_wprot();
        access("R4 wr", 24'h200100, 2'd0, 1'b1, USR, 2'b01, 1'b0, 1'b0, 1'b0, 1, 1);
        regs("R4 R9 even", 16'h9BFF, 16'h7D20, 16'h0100);
        access("R4 rd ok", 24'h200100, 2'd0, 1'b0, USR, 2'b01, 1'b0, 1'b0, 1'b0, 0, 0);
        regs("R4 R11 hold", 16'h9BFF, 16'h7D20, 16'h0100);
        access("R4 edge", 24'h080000, 2'd1, 1'b1, USR, 2'b01, 1'b1, 1'b0, 1'b0, 0, 0);
    endtask

    task automatic t_uio();
        access("R5 wr", 24'hE41000, 2'd1, 1'b1, USR, 2'b00, 1'b0, 1'b0, 1'b0, 1, 0);
        regs("R5 wr", 16'h9AFF, 16'h7CE4, 16'h1000);
        access("R5 rd", 24'h400000, 2'd3, 1'b0, USR, 2'b00, 1'b0, 1'b1, 1'b0, 1, 0);
        regs("R5 R8 rd", 16'hDEFF, 16'h7C40, 16'h0000);
    endtask

    task automatic t_prio();
        access("R6 A over B", 24'h001000, 2'd1, 1'b1, USR, 2'b00, 1'b0, 1'b0, 1'b0, 1, 1);
        regs("R6", 16'h8BFF, 16'h7C00, 16'h1000);
    endtask

    task automatic t_supv();
        access("R7 kern", 24'h001000, 2'd1, 1'b1, SUP, 2'b11, 1'b0, 1'b0, 1'b0, 0, 0);
        access("R7 io", 24'hE40000, 2'd0, 1'b0, SUP, 2'b00, 1'b0, 1'b0, 1'b0, 0, 0);
        regs("R7 R11 hold", 16'h8BFF, 16'h7C00, 16'h1000);
    endtask

    task automatic t_clear();
        @(negedge clk); clr_stat = 1'b1;
        @(negedge clk); clr_stat = 1'b0;
        regs("R12 clear", 16'hFFFF, 16'hFFFF, 16'hFFFF);
        access("R2 setup", 24'h000004, 2'd1, 1'b0, SUP, 2'b00, 1'b0, 1'b0, 1'b0, 1, 1);
        regs("R2 setup", 16'hCBFF, 16'h7C00, 16'h0004);
        access("R12 clr+flt", 24'h123456, 2'd1, 1'b1, USR, 2'b00, 1'b0, 1'b0, 1'b1, 1, 1);
        regs("R12 clear wins", 16'hFFFF, 16'hFFFF, 16'hFFFF);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_size = '0;
        acc_write = 1'b0; cpu_sr = '0; pg_state = '0; pg_wr_en = 1'b0;
        par_int_en = 1'b0; clr_stat = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_page();
        t_kernel();
        t_wprot();
        t_uio();
        t_prio();
        t_supv();
        t_clear();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule